// File: doc/BRIEF.md
# Processor-to-Host Message Channel

This block sits between a small processor core and a host test environment. The host starts the core by issuing a start command that carries the first fetch address. The block latches that address and raises a run flag toward the core. While the core runs, it reports to the host by writing an 18-bit word to one memory-mapped control register. The block splits the word into a 2-bit message kind and a 16-bit payload, then places it in a small queue.

On the host side, a decoder drains the queue whenever the host signals that it is ready. Each entry is taken exactly once and in order. A character message produces a one-cycle character pulse. An integer is sent as two half-word messages, which the decoder joins into a 32-bit value. An exit message ends the session with a sticky done flag and a pass/fail verdict. If the queue is full, the core is stalled rather than losing a message.

Top module: `hostmsg_channel`

## Requirements
- R1: While reset is held and just after it is released, `core_run`, `core_stall`, `char_valid`, `int_valid`, `done`, `pass` and `proto_err` are all low.
- R2: While `core_run` is low, a cycle with `start_valid` high sets `core_run` at the next clock edge and loads `core_start_pc` with `start_pc` (the test flow uses 0x200). Start commands that arrive while `core_run` is already high are ignored, and `core_start_pc` keeps its value.
- R3: While `core_run` is low, core writes produce no message and no stall.
- R4: A write is taken only when `wr_en` is high and `wr_addr` equals the parameter `HOST_ADDR` (default 0x780). Writes to any other address produce no message.
- R5: In `wr_data`, bits [17:16] are the message kind and bits [15:0] are the payload. The kind codes are: 0 = exit, 1 = character, 2 = integer low half, 3 = integer high half.
- R6: Messages are delivered in write order and each exactly once. When `host_ready` is high and the queue holds a message, one message is removed at the clock edge. Its result appears as a one-cycle pulse on the outputs during the following cycle.
- R7: When a valid write arrives and the queue already holds `DEPTH` messages, `core_stall` is high in that cycle and the write is not taken. The core holds the write until the stall clears, and no message is dropped or overwritten.
- R8: A character message drives `char_out` with payload bits [7:0]. Payload bits [15:8] have no effect.
- R9: A low-half message is held as pending. A later high-half message emits `int_out = {high, low}` with `int_valid`. A second low half replaces the pending one.
- R10: A high-half message with no pending low half emits no integer and sets `proto_err`, which stays high until reset.
- R11: An exit message sets `done` high until reset and sets `pass` equal to (payload == 0). Once an exit write has been taken, further core writes are ignored and never stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_valid | input | 1 | Host start command |
| start_pc | input | 32 | First fetch address carried by the start command |
| core_run | output | 1 | Core is allowed to run |
| core_start_pc | output | 32 | Latched first fetch address |
| wr_en | input | 1 | Core register-write strobe |
| wr_addr | input | 12 | Core register address |
| wr_data | input | 18 | Core register write value (kind and payload) |
| core_stall | output | 1 | Queue full; the core must hold its write |
| host_ready | input | 1 | Host accepts one message per cycle |
| char_valid | output | 1 | Character pulse |
| char_out | output | 8 | Character value |
| int_valid | output | 1 | Joined integer pulse |
| int_out | output | 32 | Joined 32-bit integer |
| done | output | 1 | Exit seen (sticky) |
| pass | output | 1 | Exit payload was zero |
| proto_err | output | 1 | High half arrived with no pending low half (sticky) |

## Verification
The assertions assume that the core holds `wr_en`, `wr_addr` and `wr_data` steady while `core_stall` is high. They also assume that every input changes only between clock edges. The bench's write task keeps the strobe and data in place until it sees the stall clear, and it drives all inputs a short delay after the rising edge. A behavioural queue model, advanced on every edge, predicts each output in every cycle, including backpressure while `host_ready` is held low.

// File: rtl/hostmsg_pkg.sv
package hostmsg_pkg;
  localparam int PAYLOAD_W = 16;
  localparam int KIND_W    = 2;
  localparam int MSG_W     = PAYLOAD_W + KIND_W;

  typedef enum logic [KIND_W-1:0] {
    KIND_EXIT   = 2'd0,
    KIND_CHAR   = 2'd1,
    KIND_INT_LO = 2'd2,
    KIND_INT_HI = 2'd3
  } msg_kind_e;

  typedef struct packed {
    msg_kind_e              kind;
    logic [PAYLOAD_W-1:0]   payload;
  } host_msg_t;

  function automatic host_msg_t split_word(input logic [MSG_W-1:0] w);
    return host_msg_t'(w);
  endfunction

  function automatic logic [2*PAYLOAD_W-1:0] join_halves(input logic [PAYLOAD_W-1:0] hi,
                                                         input logic [PAYLOAD_W-1:0] lo);
    return {hi, lo};
  endfunction

  function automatic logic [7:0] char_of(input logic [PAYLOAD_W-1:0] p);
    return p[7:0];
  endfunction
endpackage

// File: rtl/hm_fifo.sv
module hm_fifo #(
  parameter int W     = 18,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] count;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  assign dout  = mem[rd_ptr];
  assign empty = (count == '0);
  assign full  = (count == CW'(DEPTH));
endmodule

// File: rtl/hm_write_port.sv
module hm_write_port
  import hostmsg_pkg::*;
#(
  parameter int                ADDR_W    = 12,
  parameter logic [ADDR_W-1:0] HOST_ADDR = 12'h780,
  parameter int                PC_W      = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_valid,
  input  logic [PC_W-1:0]   start_pc,
  output logic              run,
  output logic [PC_W-1:0]   run_pc,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [MSG_W-1:0]  wr_data,
  input  logic              fifo_full,
  output logic              push,
  output host_msg_t         push_msg,
  output logic              stall
);
  logic closed;
  logic hit;

  assign hit      = run && !closed && wr_en && (wr_addr == HOST_ADDR);
  assign push     = hit && !fifo_full;
  assign stall    = hit && fifo_full;
  assign push_msg = split_word(wr_data);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run    <= 1'b0;
      run_pc <= '0;
      closed <= 1'b0;
    end else begin
      if (start_valid && !run) begin
        run    <= 1'b1;
        run_pc <= start_pc;
      end
      if (push && push_msg.kind == KIND_EXIT) closed <= 1'b1;
    end
  end
endmodule

// File: rtl/hm_decoder.sv
module hm_decoder
  import hostmsg_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            host_ready,
  input  logic            empty,
  input  host_msg_t       head,
  output logic            pop,
  output logic            char_valid,
  output logic [7:0]      char_out,
  output logic            int_valid,
  output logic [31:0]     int_out,
  output logic            done,
  output logic            pass,
  output logic            proto_err,
  output logic            pend_valid
);
  logic [PAYLOAD_W-1:0] pend_lo;

  assign pop = host_ready && !empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      char_valid <= 1'b0;
      char_out   <= '0;
      int_valid  <= 1'b0;
      int_out    <= '0;
      done       <= 1'b0;
      pass       <= 1'b0;
      proto_err  <= 1'b0;
      pend_valid <= 1'b0;
      pend_lo    <= '0;
    end else begin
      char_valid <= 1'b0;
      int_valid  <= 1'b0;
      if (pop) begin
        case (head.kind)
          KIND_EXIT: begin
            done <= 1'b1;
            pass <= (head.payload == '0);
          end
          KIND_CHAR: begin
            char_valid <= 1'b1;
            char_out   <= char_of(head.payload);
          end
          KIND_INT_LO: begin
            pend_valid <= 1'b1;
            pend_lo    <= head.payload;
          end
          KIND_INT_HI: begin
            if (pend_valid) begin
              int_valid  <= 1'b1;
              int_out    <= join_halves(head.payload, pend_lo);
              pend_valid <= 1'b0;
            end else begin
              proto_err  <= 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/hostmsg_channel.sv
module hostmsg_channel
  import hostmsg_pkg::*;
#(
  parameter int          ADDR_W    = 12,
  parameter logic [11:0] HOST_ADDR = 12'h780,
  parameter int          PC_W      = 32,
  parameter int          DEPTH     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_valid,
  input  logic [PC_W-1:0]   start_pc,
  output logic              core_run,
  output logic [PC_W-1:0]   core_start_pc,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [17:0]       wr_data,
  output logic              core_stall,
  input  logic              host_ready,
  output logic              char_valid,
  output logic [7:0]        char_out,
  output logic              int_valid,
  output logic [31:0]       int_out,
  output logic              done,
  output logic              pass,
  output logic              proto_err
);
  logic      push, pop, fifo_full, fifo_empty, pend_valid;
  host_msg_t push_msg;
  host_msg_t head_msg;
  logic [MSG_W-1:0] head_bits;

  hm_write_port #(.ADDR_W(ADDR_W), .HOST_ADDR(ADDR_W'(HOST_ADDR)), .PC_W(PC_W)) u_wport (
    .clk(clk), .rst_n(rst_n),
    .start_valid(start_valid), .start_pc(start_pc),
    .run(core_run), .run_pc(core_start_pc),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .fifo_full(fifo_full), .push(push), .push_msg(push_msg), .stall(core_stall)
  );

  hm_fifo #(.W(MSG_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .push(push), .din(push_msg),
    .pop(pop), .dout(head_bits),
    .empty(fifo_empty), .full(fifo_full)
  );

  assign head_msg = split_word(head_bits);

  hm_decoder u_dec (
    .clk(clk), .rst_n(rst_n),
    .host_ready(host_ready), .empty(fifo_empty), .head(head_msg),
    .pop(pop),
    .char_valid(char_valid), .char_out(char_out),
    .int_valid(int_valid), .int_out(int_out),
    .done(done), .pass(pass), .proto_err(proto_err),
    .pend_valid(pend_valid)
  );
endmodule

// File: rtl/hm_checker.sv
module hm_checker #(
  parameter int PC_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            core_run,
  input logic [PC_W-1:0] core_start_pc,
  input logic            core_stall,
  input logic            push,
  input logic            fifo_full,
  input logic            char_valid,
  input logic            int_valid,
  input logic            pend_valid,
  input logic            done,
  input logic            proto_err
);
  assert_idle_ignore_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !core_run |-> (!push && !core_stall));
  assert_pc_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    core_run |=> (core_run && $stable(core_start_pc)));
  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full |-> !push);
  assert_stall_when_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    core_stall |-> fifo_full);
  assert_one_result_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({char_valid, int_valid}));
  assert_int_after_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_valid) |-> $past(pend_valid));
  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> proto_err);
  assert_done_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);
endmodule

bind hostmsg_channel hm_checker #(.PC_W(PC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .core_run(core_run), .core_start_pc(core_start_pc),
  .core_stall(core_stall), .push(push), .fifo_full(fifo_full),
  .char_valid(char_valid), .int_valid(int_valid), .pend_valid(pend_valid),
  .done(done), .proto_err(proto_err)
);

// File: tb/sim_hostmsg_channel.sv
`timescale 1ns/1ps
module sim_hostmsg_channel;
  localparam logic [11:0] HOST = 12'h780;
  localparam int          QD   = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_valid = 1'b0; logic [31:0] start_pc = '0;
  logic wr_en = 1'b0; logic [11:0] wr_addr = '0; logic [17:0] wr_data = '0;
  logic host_ready = 1'b0;
  logic core_run, core_stall, char_valid, int_valid, done, pass, proto_err;
  logic [31:0] core_start_pc, int_out;
  logic [7:0]  char_out;

  always #5 clk = ~clk;

  hostmsg_channel u0 (
    .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_pc(start_pc),
    .core_run(core_run), .core_start_pc(core_start_pc),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .core_stall(core_stall),
    .host_ready(host_ready), .char_valid(char_valid), .char_out(char_out),
    .int_valid(int_valid), .int_out(int_out), .done(done), .pass(pass),
    .proto_err(proto_err)
  );

  int n_chk = 0, n_fail = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // behavioural reference model
  logic [17:0] q[$];
  bit m_run, m_closed, m_pend, m_err, m_done, m_pass, m_cv, m_iv;
  logic [31:0] m_pc, m_int; logic [15:0] m_lo; logic [7:0] m_ch;

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); m_run = 0; m_closed = 0; m_pend = 0; m_err = 0; m_done = 0;
      m_pass = 0; m_cv = 0; m_iv = 0; m_pc = 0; m_int = 0; m_lo = 0; m_ch = 0;
    end else begin
      bit acc; bit pop; logic [17:0] m;
      acc = m_run && !m_closed && wr_en && wr_addr == HOST && q.size() < QD;
      pop = host_ready && q.size() > 0;
      m_cv = 0; m_iv = 0;
      if (pop) begin
        m = q.pop_front();
        if (m[17:16] == 2'd0) begin m_done = 1; m_pass = (m[15:0] == 16'd0); end
        else if (m[17:16] == 2'd1) begin m_cv = 1; m_ch = m[7:0]; end
        else if (m[17:16] == 2'd2) begin m_pend = 1; m_lo = m[15:0]; end
        else if (m_pend) begin m_iv = 1; m_int = {m[15:0], m_lo}; m_pend = 0; end
        else m_err = 1;
      end
      if (acc) begin
        q.push_back(wr_data);
        if (wr_data[17:16] == 2'd0) m_closed = 1;
      end
      if (start_valid && !m_run) begin m_run = 1; m_pc = start_pc; end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2 core_run", core_run, m_run);
      chk("R2 core_start_pc", core_start_pc, m_pc);
      chk("R7 core_stall", core_stall,
          m_run && !m_closed && wr_en && wr_addr == HOST && q.size() == QD);
      chk("R6 char_valid", char_valid, m_cv);
      if (m_cv) chk("R8 char_out", char_out, m_ch);
      chk("R9 int_valid", int_valid, m_iv);
      if (m_iv) chk("R9 int_out", int_out, m_int);
      chk("R11 done", done, m_done);
      chk("R11 pass", pass, m_pass);
      chk("R10 proto_err", proto_err, m_err);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic core_write(input logic [11:0] a, input logic [17:0] d);
    logic st;
    wr_en = 1; wr_addr = a; wr_data = d;
    do begin
      @(negedge clk); st = core_stall;
      @(posedge clk); #2;
    end while (st);
    wr_en = 0;
  endtask

  task automatic do_reset();
    rst_n = 0; start_valid = 0; wr_en = 0; host_ready = 0;
    tick(3);
    rst_n = 1;
    #1;
    chk("R1 core_run", core_run, 0);
    chk("R1 core_stall", core_stall, 0);
    chk("R1 flags", {char_valid, int_valid, done, pass, proto_err}, 0);
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #1ms;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    do_reset();
    host_ready = 1;
    // R3: write before start is ignored
    core_write(HOST, {2'd1, 16'h0041});
    tick(2);
    chk("R3 no char before start", char_valid, 0);
    // R2: start
    start_valid = 1; start_pc = 32'h200; tick(1); start_valid = 0;
    chk("R2 run", core_run, 1);
    chk("R2 pc", core_start_pc, 32'h200);
    start_valid = 1; start_pc = 32'h400; tick(1); start_valid = 0;
    chk("R2 second start ignored", core_start_pc, 32'h200);
    // R4: other address
    core_write(12'h781, {2'd1, 16'h0042});
    tick(2);
    chk("R4 other address", char_valid, 0);
    // R5 R8: character with high payload bits set
    core_write(HOST, {2'd1, 16'h1F41});
    @(posedge clk); @(negedge clk);
    chk("R8 char valid", char_valid, 1);
    chk("R8 char low byte", char_out, 8'h41);
    tick(1);
    // R9: joined integer
    core_write(HOST, {2'd2, 16'h5678});
    core_write(HOST, {2'd3, 16'h1234});
    @(posedge clk); @(negedge clk);
    chk("R9 int valid", int_valid, 1);
    chk("R9 int value", int_out, 32'h12345678);
    tick(1);
    // R9: second low half replaces first
    core_write(HOST, {2'd2, 16'h1111});
    core_write(HOST, {2'd2, 16'h2222});
    core_write(HOST, {2'd3, 16'hABCD});
    @(posedge clk); @(negedge clk);
    chk("R9 replaced low", int_out, 32'hABCD2222);
    tick(1);
    // R10: orphan high half
    core_write(HOST, {2'd3, 16'h9999});
    tick(2);
    chk("R10 proto_err", proto_err, 1);
    chk("R10 no int", int_valid, 0);
    // R7: backpressure
    host_ready = 0;
    for (int i = 0; i < QD; i++) core_write(HOST, {2'd1, 16'(8'h60 + i)});
    fork
      core_write(HOST, {2'd1, 16'h0070});
      begin
        @(negedge clk);
        chk("R7 stall when full", core_stall, 1);
        tick(4);
        host_ready = 1;
      end
    join
    tick(QD + 3);
    // R6: in-order, consumed once; mixed stream back to back
    core_write(HOST, {2'd1, 16'h0031});
    core_write(HOST, {2'd2, 16'hBEEF});
    core_write(HOST, {2'd3, 16'hDEAD});
    tick(3);
    // R11: exit pass, later writes ignored
    core_write(HOST, {2'd0, 16'h0000});
    @(posedge clk); @(negedge clk);
    chk("R11 done", done, 1);
    chk("R11 pass", pass, 1);
    tick(1);
    core_write(HOST, {2'd1, 16'h0055});
    tick(2);
    chk("R11 write after exit", char_valid, 0);
    chk("R11 done sticky", done, 1);
    // R11: failing exit after fresh reset
    do_reset();
    host_ready = 1;
    start_valid = 1; start_pc = 32'h200; tick(1); start_valid = 0;
    core_write(HOST, {2'd0, 16'h0003});
    @(posedge clk); @(negedge clk);
    chk("R11 done fail", done, 1);
    chk("R11 pass low", pass, 0);
    tick(3);
    report();
  end
endmodule